// File: doc/BRIEF.md
# Pipelined CORDIC Square Root

This block returns the square root of a non-negative signed fixed-point operand. Every CORDIC rotation has its own hardware stage, so the block takes a new operand on any clock cycle. A normalizer runs first and scales the operand by an even power of two into the range where hyperbolic vectoring converges. The rotation cascade then drives the y coordinate toward zero. A last stage removes the CORDIC gain with a constant multiply, undoes the normalization and rounds the result.

Both sides use a valid/ready handshake. The upstream ready is the downstream ready, passed through with no logic. Every pipeline register is clock-enabled by that downstream ready, so backpressure freezes the whole pipe at once. A synchronous restart input clears the valid bits of all stages and leaves the data registers alone. Each operand carries its own normalization exponent and zero flag down the pipe. This lets operands of any size sit in the pipe together.

Top module: `csqrt_pipe`

## Requirements
- R1: `up_ready` equals `dn_ready` in every cycle, including while `rst_n` is low.
- R2: An operand is taken at a rising edge where `up_valid` and `up_ready` are both high. With `dn_ready` held high, its result appears with `dn_valid` high exactly 23 cycles later, and `dn_valid` is still low at 22 cycles.
- R3: Operands offered on consecutive cycles are all accepted. Their results come out on consecutive cycles in the same order.
- R4: Input and output are 16-bit two's complement values with 10 fraction bits (bit 15 is the sign). For an input code `u` in 0..32767, the output code is within 1 of round(32·sqrt(u)), and its sign bit is never set.
- R5: An input code of 0 gives an output code of exactly 0.
- R6: While `dn_ready` is low, no stage advances. `dn_valid` and `dn_data` hold their values, and operands already in the pipe are delayed by exactly the number of stalled cycles.
- R7: A high `restart` at a rising edge discards every operand in flight, including one offered in that same cycle. None of these produces a `dn_valid` pulse.
- R8: Driving `rst_n` low clears `dn_valid` at once, without waiting for a clock, and discards every operand in flight.
- R9: The range ends are handled: input code 1 gives 32, and input code 32767 gives 5793 (within 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous flush of all valid bits |
| up_valid | input | 1 | Operand valid |
| up_ready | output | 1 | Operand ready (copy of dn_ready) |
| up_data | input | 16 | Operand, signed Q5.10, non-negative |
| dn_valid | output | 1 | Result valid |
| dn_ready | input | 1 | Result ready; clock enable for the whole pipe |
| dn_data | output | 16 | Square root, signed Q5.10 |

## Verification
The assertions assume four things about the inputs:
- `rst_n` is released in step with the clock.
- `restart` is sampled only at rising edges.
- Operands are never negative.
- Any change to the handshake inputs is settled before the next rising edge.

The bench keeps to these assumptions. It changes `rst_n`, `restart`, `up_valid`, `up_data` and `dn_ready` only at falling clock edges, and it only draws operand codes from 0 to 32767. The hold and freeze properties exclude cycles where `restart` is high, because a restart is allowed to drop a stalled result.

// File: rtl/csqrt_pkg.sv
package csqrt_pkg;

  // 1/An for the hyperbolic gain, scaled by 2^GAIN_FRAC
  localparam int GAIN_FRAC = 16;
  localparam int unsigned GAIN_CODE = 32'd79135;

  // number of rotations for shifts 1..max_sh, with the 4, 13, 40 ... repeats
  function automatic int rot_count(input int max_sh);
    int n;
    int rep;
    n   = 0;
    rep = 4;
    for (int s = 1; s <= max_sh; s++) begin
      n = n + 1;
      if (s == rep) begin
        n   = n + 1;
        rep = 3 * rep + 1;
      end
    end
    return n;
  endfunction

  // shift amount used by rotation number idx
  function automatic int rot_shift(input int idx, input int max_sh);
    int n;
    int rep;
    int res;
    n   = 0;
    rep = 4;
    res = max_sh;
    for (int s = 1; s <= max_sh; s++) begin
      if (n == idx) res = s;
      n = n + 1;
      if (s == rep) begin
        if (n == idx) res = s;
        n   = n + 1;
        rep = 3 * rep + 1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/csqrt_norm.sv
module csqrt_norm #(
  parameter int W     = 16,
  parameter int GUARD = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  en,
  input  logic                                  clr,
  input  logic                                  in_v,
  input  logic [W-1:0]                          in_u,
  output logic                                  out_v,
  output logic signed [W-2+GUARD+4-1:0]         out_x,
  output logic signed [W-2+GUARD+4-1:0]         out_y,
  output logic [$clog2(W/2)-1:0]                out_k,
  output logic                                  out_z
);
  localparam int NS = $clog2(W) - 1;   // even-shift steps: 2^NS .. 2
  localparam int MW = W - 1;           // magnitude bits
  localparam int FI = W - 2 + GUARD;   // internal fraction bits
  localparam int IW = FI + 4;
  localparam int KW = $clog2(W / 2);
  localparam logic signed [IW-1:0] QTR = IW'(1) << (FI - 2);

  logic              v_q [0:NS];
  logic [MW-1:0]     m_q [0:NS];
  logic [KW-1:0]     k_q [0:NS];
  logic [MW-1:0]     m_d [1:NS];
  logic [KW-1:0]     k_d [1:NS];
  logic signed [IW-1:0] base, x_d, y_d;
  logic              z_d;

  // leading-zero shifter in even steps
  always_comb begin
    for (int i = 0; i < NS; i++) begin
      m_d[i+1] = m_q[i];
      k_d[i+1] = k_q[i];
      if ((m_q[i] >> (MW - (1 << (NS - i)))) == '0) begin
        m_d[i+1] = m_q[i] << (1 << (NS - i));
        k_d[i+1] = k_q[i] + KW'((1 << (NS - i)) >> 1);
      end
    end
  end

  // starting vector (v + 1/4, v - 1/4)
  always_comb begin
    base = $signed({{(IW - MW){1'b0}}, m_q[NS]}) <<< GUARD;
    x_d  = base + QTR;
    y_d  = base - QTR;
    z_d  = (m_q[NS] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= NS; i++) v_q[i] <= 1'b0;
      out_v <= 1'b0;
    end else if (clr) begin
      for (int i = 0; i <= NS; i++) v_q[i] <= 1'b0;
      out_v <= 1'b0;
    end else if (en) begin
      v_q[0] <= in_v;
      for (int i = 0; i < NS; i++) v_q[i+1] <= v_q[i];
      out_v <= v_q[NS];
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      m_q[0] <= in_u[MW-1:0];
      k_q[0] <= '0;
      for (int i = 0; i < NS; i++) begin
        m_q[i+1] <= m_d[i+1];
        k_q[i+1] <= k_d[i+1];
      end
      out_x <= x_d;
      out_y <= y_d;
      out_k <= k_q[NS];
      out_z <= z_d;
    end
  end

endmodule

// File: rtl/csqrt_rot.sv
module csqrt_rot #(
  parameter int IW    = 22,
  parameter int KW    = 3,
  parameter int SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic                 in_v,
  input  logic signed [IW-1:0] in_x,
  input  logic signed [IW-1:0] in_y,
  input  logic [KW-1:0]        in_k,
  input  logic                 in_z,
  output logic                 out_v,
  output logic signed [IW-1:0] out_x,
  output logic signed [IW-1:0] out_y,
  output logic [KW-1:0]        out_k,
  output logic                 out_z
);
  logic signed [IW-1:0] x_d, y_d;

  // rotate so that y moves toward zero
  always_comb begin
    if (in_y[IW-1]) begin
      x_d = in_x + (in_y >>> SHIFT);
      y_d = in_y + (in_x >>> SHIFT);
    end else begin
      x_d = in_x - (in_y >>> SHIFT);
      y_d = in_y - (in_x >>> SHIFT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_v <= 1'b0;
    else if (clr)   out_v <= 1'b0;
    else if (en)    out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_x <= x_d;
      out_y <= y_d;
      out_k <= in_k;
      out_z <= in_z;
    end
  end

endmodule

// File: rtl/csqrt_post.sv
module csqrt_post
  import csqrt_pkg::*;
#(
  parameter int W     = 16,
  parameter int F     = 10,
  parameter int GUARD = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          clr,
  input  logic                          in_v,
  input  logic signed [W-2+GUARD+4-1:0] in_x,
  input  logic [$clog2(W/2)-1:0]        in_k,
  input  logic                          in_z,
  output logic                          out_v,
  output logic [W-1:0]                  out_q
);
  localparam int FI     = W - 2 + GUARD;
  localparam int IW     = FI + 4;
  localparam int HALF_E = (W - 2 - F) / 2;
  localparam int BASE   = FI + GAIN_FRAC - F - HALF_E;
  localparam int PW     = IW + GAIN_FRAC + 2;

  logic [PW-1:0] prod, rnd;
  logic [W-1:0]  q_d;
  int            sh;

  // gain removal, exponent restore, round to nearest
  always_comb begin
    prod = PW'($unsigned(in_x)) * PW'(GAIN_CODE);
    sh   = BASE + int'(in_k);
    rnd  = prod + (PW'(1) << (sh - 1));
    q_d  = in_z ? '0 : W'(rnd >> sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_v <= 1'b0;
    else if (clr)   out_v <= 1'b0;
    else if (en)    out_v <= in_v;
  end

  always_ff @(posedge clk) begin
    if (en) out_q <= q_d;
  end

endmodule

// File: rtl/csqrt_pipe.sv
module csqrt_pipe
  import csqrt_pkg::*;
#(
  parameter int W         = 16,
  parameter int F         = 10,
  parameter int GUARD     = 4,
  parameter int MAX_SHIFT = W - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  localparam int NR = rot_count(MAX_SHIFT);
  localparam int FI = W - 2 + GUARD;
  localparam int IW = FI + 4;
  localparam int KW = $clog2(W / 2);

  logic en;
  assign en       = dn_ready;
  assign up_ready = dn_ready;

  logic                 cv [0:NR];
  logic signed [IW-1:0] cx [0:NR];
  logic signed [IW-1:0] cy [0:NR];
  logic [KW-1:0]        ck [0:NR];
  logic                 cz [0:NR];

  csqrt_norm #(.W(W), .GUARD(GUARD)) u_norm (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(restart),
    .in_v(up_valid), .in_u(up_data),
    .out_v(cv[0]), .out_x(cx[0]), .out_y(cy[0]), .out_k(ck[0]), .out_z(cz[0])
  );

  for (genvar j = 0; j < NR; j++) begin : g_rot
    csqrt_rot #(.IW(IW), .KW(KW), .SHIFT(rot_shift(j, MAX_SHIFT))) u_rot (
      .clk(clk), .rst_n(rst_n), .en(en), .clr(restart),
      .in_v(cv[j]), .in_x(cx[j]), .in_y(cy[j]), .in_k(ck[j]), .in_z(cz[j]),
      .out_v(cv[j+1]), .out_x(cx[j+1]), .out_y(cy[j+1]), .out_k(ck[j+1]), .out_z(cz[j+1])
    );
  end

  csqrt_post #(.W(W), .F(F), .GUARD(GUARD)) u_post (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(restart),
    .in_v(cv[NR]), .in_x(cx[NR]), .in_k(ck[NR]), .in_z(cz[NR]),
    .out_v(dn_valid), .out_q(dn_data)
  );

endmodule

// File: rtl/csqrt_pipe_chk.sv
module csqrt_pipe_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         restart,
  input logic         dn_ready,
  input logic         dn_valid,
  input logic [W-1:0] dn_data
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready && !restart) |=> (dn_valid && $stable(dn_data)))
    else $error("held result changed under backpressure"); // R6

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_ready && !restart) |=> $stable(dn_valid))
    else $error("valid moved while stalled"); // R6

  AST_RESTART_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !dn_valid)
    else $error("valid survived restart"); // R7

  AST_RESULT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !dn_data[W-1])
    else $error("negative root"); // R4

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dn_valid)
    else $error("valid right after reset"); // R8
endmodule

bind csqrt_pipe csqrt_pipe_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart),
  .dn_ready(dn_ready), .dn_valid(dn_valid), .dn_data(dn_data)
);

// File: tb/csqrt_pipe_tb_top.sv
`timescale 1ns/1ps
module csqrt_pipe_tb_top;
  localparam int LAT  = 23;
  localparam int NTBL = 15;
  localparam int NMAX = 512;

  // {operand code, expected root code}
  localparam logic [31:0] TBL [0:NTBL-1] = '{
    {16'd0,     16'd0},    {16'd1,     16'd32},   {16'd4,     16'd64},
    {16'd9,     16'd96},   {16'd49,    16'd224},  {16'd100,   16'd320},
    {16'd256,   16'd512},  {16'd1024,  16'd1024}, {16'd2025,  16'd1440},
    {16'd4096,  16'd2048}, {16'd12321, 16'd3552}, {16'd16384, 16'd4096},
    {16'd25600, 16'd5120}, {16'd32761, 16'd5792}, {16'd32767, 16'd5793}
  };

  logic        clk = 1'b0;
  logic        rst_n, restart, up_valid, dn_ready;
  logic        up_ready, dn_valid;
  logic [15:0] up_data, dn_data;

  int n_chk = 0;
  int n_bad = 0;
  int stim [0:NMAX-1];
  int expv [0:NMAX-1];

  always #5 clk = ~clk;

  csqrt_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int u);
    if (u == 0) return "R5";
    if (u == 1 || u == 32767) return "R9";
    return "R4";
  endfunction

  // offer n operands back to back; results checked 23 cycles later
  task automatic stream(input int n);
    int d;
    for (int c = 0; c < n + LAT + 1; c++) begin
      @(negedge clk);
      if (c == LAT - 1) chk(dn_valid == 1'b0, "R2", int'(dn_valid), 0);
      if (c >= LAT && c - LAT < n) begin
        chk(dn_valid == 1'b1, "R3", int'(dn_valid), 1);
        d = int'(dn_data) - expv[c-LAT];
        if (d < 0) d = -d;
        if (expv[c-LAT] == 0)
          chk(dn_data == 16'd0, "R5", int'(dn_data), 0);
        else
          chk(d <= 1, tag_of(stim[c-LAT]), int'(dn_data), expv[c-LAT]);
      end
      up_valid = (c < n);
      if (c < n) up_data = 16'(stim[c]);
    end
    up_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    rst_n = 1'b0; restart = 1'b0; up_valid = 1'b0; up_data = '0; dn_ready = 1'b1;

    // reset state, ready pass-through during reset
    repeat (3) @(negedge clk);
    chk(dn_valid == 1'b0, "R8", int'(dn_valid), 0);
    chk(up_ready == 1'b1, "R1", int'(up_ready), 1);
    dn_ready = 1'b0; #1;
    chk(up_ready == 1'b0, "R1", int'(up_ready), 0);
    dn_ready = 1'b1;
    @(negedge clk); rst_n = 1'b1;

    // table of exact roots, back to back
    for (int i = 0; i < NTBL; i++) begin
      stim[i] = int'(TBL[i][31:16]);
      expv[i] = int'(TBL[i][15:0]);
    end
    stream(NTBL);

    // sweep against a real-valued root
    for (int i = 0; i < 400; i++) begin
      stim[i] = i * 81 + 7;
      expv[i] = $rtoi($sqrt(real'(stim[i])) * 32.0 + 0.5);
    end
    stream(400);

    // stall: 10 active cycles, 20 frozen, then 13 more
    @(negedge clk); up_valid = 1'b1; up_data = 16'd1024;
    @(negedge clk); up_valid = 1'b0;
    repeat (8) @(negedge clk);
    @(negedge clk); dn_ready = 1'b0; #1;
    chk(up_ready == 1'b0, "R1", int'(up_ready), 0);
    repeat (20) @(negedge clk);
    chk(dn_valid == 1'b0, "R6", int'(dn_valid), 0);
    dn_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk(dn_valid == 1'b0, "R6", int'(dn_valid), 0);
    @(negedge clk);
    chk(dn_valid == 1'b1, "R6", int'(dn_valid), 1);
    chk(dn_data == 16'd1024, "R6", int'(dn_data), 1024);
    dn_ready = 1'b0;
    repeat (5) @(negedge clk);
    chk(dn_valid == 1'b1 && dn_data == 16'd1024, "R6", int'(dn_data), 1024);
    dn_ready = 1'b1;
    @(negedge clk);
    chk(dn_valid == 1'b0, "R6", int'(dn_valid), 0);

    // restart flushes in-flight operands and one offered alongside it
    for (int c = 0; c < 5; c++) begin
      @(negedge clk); up_valid = 1'b1; up_data = 16'd4096;
    end
    @(negedge clk); up_valid = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge clk); restart = 1'b1; up_valid = 1'b1; up_data = 16'd100;
    @(negedge clk); restart = 1'b0; up_valid = 1'b0;
    seen = 1'b0;
    repeat (35) begin
      @(negedge clk);
      if (dn_valid) seen = 1'b1;
    end
    chk(seen == 1'b0, "R7", int'(seen), 0);

    // asynchronous reset in flight
    for (int c = 0; c < 30; c++) begin
      @(negedge clk); up_valid = (c < 6); up_data = 16'd9;
      if (c == 24) begin
        rst_n = 1'b0; #1;
        chk(dn_valid == 1'b0, "R8", int'(dn_valid), 0);
      end
    end
    up_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    seen = 1'b0;
    repeat (30) begin
      @(negedge clk);
      if (dn_valid) seen = 1'b1;
    end
    chk(seen == 1'b0, "R8", int'(seen), 0);

    // recovery after flushes
    for (int i = 0; i < NTBL; i++) begin
      stim[i] = int'(TBL[i][31:16]);
      expv[i] = int'(TBL[i][15:0]);
    end
    stream(NTBL);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule